// File: doc/BRIEF.md
# Integer Execution Unit with Overflow Trap

This block is the combinational integer datapath of a simple load/store processor core. Every cycle it receives the two source register values, the 16-bit immediate and the 5-bit constant shift amount of the current instruction, together with a 5-bit operation code. It returns the computed word and a signed-overflow trap flag. It also returns a write-enable that tells the register file whether the destination may be written.

It covers these operation groups:
- add and subtract, each in a trapping and a non-trapping form, with register and immediate operands;
- the four bitwise operations, with zero-extended immediate forms for AND, OR and XOR;
- left, logical-right and arithmetic-right shifts, by a constant or by a register amount;
- signed less-than, in register and immediate forms;
- leading-zero and leading-one counts.

Every add, subtract and compare shares one adder. A trapping operation that overflows suppresses the register write. Instruction decode, the register file, multiply/divide and memory access lie outside the block.

Top module: `int_exec_unit`

## Requirements
- R1: The operation code selects the function: 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 ADDI, 5 ADDIU, 6 AND, 7 OR, 8 XOR, 9 NOR, 10 ANDI, 11 ORI, 12 XORI, 13 SLL, 14 SRL, 15 SRA, 16 SLLV, 17 SRLV, 18 SRAV, 19 SLT, 20 SLTI, 21 CLZ, 22 CLO. Add and subtract results wrap modulo 2^32.
- R2: ADD, ADDI and SUB raise the trap flag exactly when the signed result cannot be represented in 32 bits. The result port still carries the wrapped value.
- R3: ADDU, ADDIU and SUBU never raise the trap flag, and neither does any other operation outside those named in R2.
- R4: Write-enable is low whenever the trap flag is high, and also for any code above 22. Such undefined codes return a zero result and no trap. In every other case write-enable is high.
- R5: ADDI, ADDIU and SLTI sign-extend the 16-bit immediate, copying its bit 15 into result bits 31..16.
- R6: ANDI, ORI and XORI zero-extend the 16-bit immediate.
- R7: AND, OR, XOR and NOR combine the two register operands bit by bit. NOR yields the complement of the OR.
- R8: SLL, SRL and SRA shift the second register operand by the constant shift amount. SRA fills vacated bits with bit 31; SLL and SRL fill with zeros. An amount of 0 returns the operand unchanged.
- R9: SLLV, SRLV and SRAV shift the second register operand by bits 4..0 of the first register operand. Its upper bits and the constant shift amount port have no effect.
- R10: SLT and SLTI return 1 when the first operand is less than the second under a signed comparison, and 0 otherwise. This holds even where the difference itself overflows.
- R11: CLZ and CLO return the number of leading zero or leading one bits of the first register operand. An all-zero input to CLZ returns 32, and so does an all-ones input to CLO.

Port order below follows the port list. The shift amount port is `$clog2(XLEN)` bits wide and the immediate port is `IMMW` bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code (R1 encoding) |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| imm_i | input | 16 | Instruction immediate |
| shamt_i | input | 5 | Constant shift amount |
| result_o | output | 32 | Computed result |
| ovf_trap_o | output | 1 | Signed-overflow trap |
| wr_en_o | output | 1 | Destination write allowed |

## Verification
Some properties are checked by in-line assertions on every evaluation:
- the trap flag and write-enable are never high together;
- non-trapping adds and subtracts stay silent;
- a flagged ADD really had same-signed operands and a flipped result sign;
- compare results are a single bit;
- counts never exceed the word width;
- a zero shift is the identity;
- a set top bit gives a zero count.

The arithmetic values themselves can only be shown by the bench's directed scenarios. These include the fill behaviour of each shift, immediate extension, the ignored upper bits of a variable shift amount, signed comparison across the overflow boundary, and the all-zero and all-ones count limits.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   localparam int OPW = 5;

   typedef enum logic [OPW-1:0] {
      OP_ADD   = 5'd0,
      OP_ADDU  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBU  = 5'd3,
      OP_ADDI  = 5'd4,
      OP_ADDIU = 5'd5,
      OP_AND   = 5'd6,
      OP_OR    = 5'd7,
      OP_XOR   = 5'd8,
      OP_NOR   = 5'd9,
      OP_ANDI  = 5'd10,
      OP_ORI   = 5'd11,
      OP_XORI  = 5'd12,
      OP_SLL   = 5'd13,
      OP_SRL   = 5'd14,
      OP_SRA   = 5'd15,
      OP_SLLV  = 5'd16,
      OP_SRLV  = 5'd17,
      OP_SRAV  = 5'd18,
      OP_SLT   = 5'd19,
      OP_SLTI  = 5'd20,
      OP_CLZ   = 5'd21,
      OP_CLO   = 5'd22
   } alu_op_e;

   typedef enum logic [2:0] {
      GRP_NONE  = 3'd0,
      GRP_ARITH = 3'd1,
      GRP_BITOP = 3'd2,
      GRP_SHIFT = 3'd3,
      GRP_LESS  = 3'd4,
      GRP_COUNT = 3'd5
   } res_grp_e;

   typedef enum logic [1:0] {
      BIT_AND = 2'd0,
      BIT_OR  = 2'd1,
      BIT_XOR = 2'd2,
      BIT_NOR = 2'd3
   } bit_fn_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RLOG  = 2'd1,
      SH_RARI  = 2'd2
   } sh_kind_e;

   typedef struct packed {
      logic     valid;
      logic     use_imm;
      logic     imm_sext;
      logic     subtract;
      logic     may_trap;
      bit_fn_e  bit_fn;
      sh_kind_e sh_kind;
      logic     sh_var;
      logic     cnt_ones;
      res_grp_e grp;
   } alu_ctl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
   import int_alu_pkg::*;
(
   input  logic [OPW-1:0] op_i,
   output alu_ctl_t       ctl_o
);

   always_comb begin
      ctl_o = '{valid: 1'b1, use_imm: 1'b0, imm_sext: 1'b0, subtract: 1'b0,
                may_trap: 1'b0, bit_fn: BIT_AND, sh_kind: SH_LEFT,
                sh_var: 1'b0, cnt_ones: 1'b0, grp: GRP_NONE};
      case (op_i)
         OP_ADD:   begin ctl_o.grp = GRP_ARITH; ctl_o.may_trap = 1'b1; end
         OP_ADDU:  begin ctl_o.grp = GRP_ARITH; end
         OP_SUB:   begin ctl_o.grp = GRP_ARITH; ctl_o.subtract = 1'b1;
                         ctl_o.may_trap = 1'b1; end
         OP_SUBU:  begin ctl_o.grp = GRP_ARITH; ctl_o.subtract = 1'b1; end
         OP_ADDI:  begin ctl_o.grp = GRP_ARITH; ctl_o.use_imm = 1'b1;
                         ctl_o.imm_sext = 1'b1; ctl_o.may_trap = 1'b1; end
         OP_ADDIU: begin ctl_o.grp = GRP_ARITH; ctl_o.use_imm = 1'b1;
                         ctl_o.imm_sext = 1'b1; end
         OP_AND:   begin ctl_o.grp = GRP_BITOP; ctl_o.bit_fn = BIT_AND; end
         OP_OR:    begin ctl_o.grp = GRP_BITOP; ctl_o.bit_fn = BIT_OR;  end
         OP_XOR:   begin ctl_o.grp = GRP_BITOP; ctl_o.bit_fn = BIT_XOR; end
         OP_NOR:   begin ctl_o.grp = GRP_BITOP; ctl_o.bit_fn = BIT_NOR; end
         OP_ANDI:  begin ctl_o.grp = GRP_BITOP; ctl_o.bit_fn = BIT_AND;
                         ctl_o.use_imm = 1'b1; end
         OP_ORI:   begin ctl_o.grp = GRP_BITOP; ctl_o.bit_fn = BIT_OR;
                         ctl_o.use_imm = 1'b1; end
         OP_XORI:  begin ctl_o.grp = GRP_BITOP; ctl_o.bit_fn = BIT_XOR;
                         ctl_o.use_imm = 1'b1; end
         OP_SLL:   begin ctl_o.grp = GRP_SHIFT; ctl_o.sh_kind = SH_LEFT; end
         OP_SRL:   begin ctl_o.grp = GRP_SHIFT; ctl_o.sh_kind = SH_RLOG; end
         OP_SRA:   begin ctl_o.grp = GRP_SHIFT; ctl_o.sh_kind = SH_RARI; end
         OP_SLLV:  begin ctl_o.grp = GRP_SHIFT; ctl_o.sh_kind = SH_LEFT;
                         ctl_o.sh_var = 1'b1; end
         OP_SRLV:  begin ctl_o.grp = GRP_SHIFT; ctl_o.sh_kind = SH_RLOG;
                         ctl_o.sh_var = 1'b1; end
         OP_SRAV:  begin ctl_o.grp = GRP_SHIFT; ctl_o.sh_kind = SH_RARI;
                         ctl_o.sh_var = 1'b1; end
         OP_SLT:   begin ctl_o.grp = GRP_LESS; ctl_o.subtract = 1'b1; end
         OP_SLTI:  begin ctl_o.grp = GRP_LESS; ctl_o.subtract = 1'b1;
                         ctl_o.use_imm = 1'b1; ctl_o.imm_sext = 1'b1; end
         OP_CLZ:   begin ctl_o.grp = GRP_COUNT; end
         OP_CLO:   begin ctl_o.grp = GRP_COUNT; ctl_o.cnt_ones = 1'b1; end
         default:  begin ctl_o.valid = 1'b0; end
      endcase
   end

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            sub_i,
   output logic [XLEN-1:0] sum_o,
   output logic            ovf_o
);

   logic [XLEN-1:0] b_eff;

   always_comb begin
      b_eff = sub_i ? ~b_i : b_i;
      sum_o = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
      ovf_o = (a_i[XLEN-1] == b_eff[XLEN-1]) && (sum_o[XLEN-1] != a_i[XLEN-1]);
   end

endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter
   import int_alu_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int IMPL = 0,
   localparam int SHW = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] val_i,
   input  logic [SHW-1:0]  amt_i,
   input  sh_kind_e        kind_i,
   output logic [XLEN-1:0] out_o
);

   if (IMPL == 0) begin : g_staged
      logic            fill;
      logic            left;
      logic [XLEN-1:0] src;
      logic [XLEN-1:0] st [SHW+1];

      always_comb begin
         left = (kind_i == SH_LEFT);
         fill = (kind_i == SH_RARI) & val_i[XLEN-1];
         for (int i = 0; i < XLEN; i++) begin
            src[i] = left ? val_i[XLEN-1-i] : val_i[i];
         end
      end

      assign st[0] = src;

      for (genvar s = 0; s < SHW; s++) begin : g_stage
         localparam int D = 1 << s;
         assign st[s+1] = amt_i[s] ? {{D{fill}}, st[s][XLEN-1:D]} : st[s];
      end

      always_comb begin
         for (int i = 0; i < XLEN; i++) begin
            out_o[i] = left ? st[SHW][XLEN-1-i] : st[SHW][i];
         end
      end
   end else begin : g_direct
      always_comb begin
         case (kind_i)
            SH_LEFT: out_o = val_i << amt_i;
            SH_RLOG: out_o = val_i >> amt_i;
            default: out_o = $unsigned($signed(val_i) >>> amt_i);
         endcase
      end
   end

   always_comb begin
      if (amt_i == '0) begin
         AST_SHIFT_ZERO_IDENT: assert (out_o == val_i); // R8
      end
   end

endmodule

// File: rtl/int_alu_lzc.sv
module int_alu_lzc #(
   parameter int XLEN = 32,
   parameter int IMPL = 1,
   localparam int CW = $clog2(XLEN) + 1
) (
   input  logic [XLEN-1:0] val_i,
   output logic [CW-1:0]   cnt_o
);

   if (IMPL == 0) begin : g_scan
      logic found;
      always_comb begin
         cnt_o = CW'(XLEN);
         found = 1'b0;
         for (int i = XLEN - 1; i >= 0; i--) begin
            if (!found && val_i[i]) begin
               cnt_o = CW'(XLEN - 1 - i);
               found = 1'b1;
            end
         end
      end
   end else begin : g_tree
      localparam int NODES = 2 * XLEN - 1;
      logic [CW-1:0] cnt  [NODES];
      logic          zero [NODES];

      for (genvar j = 0; j < XLEN; j++) begin : g_leaf
         assign zero[XLEN-1+j] = ~val_i[XLEN-1-j];
         assign cnt[XLEN-1+j]  = {{(CW-1){1'b0}}, ~val_i[XLEN-1-j]};
      end

      for (genvar k = 0; k < XLEN - 1; k++) begin : g_node
         localparam int DEPTH = $clog2(k + 2) - 1;
         localparam int CHILD = XLEN >> (DEPTH + 1);
         assign zero[k] = zero[2*k+1] & zero[2*k+2];
         assign cnt[k]  = zero[2*k+1] ? (CW'(CHILD) + cnt[2*k+2]) : cnt[2*k+1];
      end

      assign cnt_o = cnt[0];
   end

   always_comb begin
      if (val_i[XLEN-1]) begin
         AST_LEAD_BIT_ZERO_COUNT: assert (cnt_o == '0); // R11
      end
   end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import int_alu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int IMMW       = 16,
   parameter int SHIFT_IMPL = 0,
   parameter int LZC_IMPL   = 1,
   localparam int SHW       = $clog2(XLEN),
   localparam int CW        = SHW + 1
) (
   input  logic [OPW-1:0]  op_i,
   input  logic [XLEN-1:0] rs_val_i,
   input  logic [XLEN-1:0] rt_val_i,
   input  logic [IMMW-1:0] imm_i,
   input  logic [SHW-1:0]  shamt_i,
   output logic [XLEN-1:0] result_o,
   output logic            ovf_trap_o,
   output logic            wr_en_o
);

   if ((XLEN & (XLEN - 1)) != 0 || XLEN <= IMMW) begin : g_bad_width
      $error("int_exec_unit: XLEN must be a power of two wider than IMMW");
   end
   if (SHIFT_IMPL < 0 || SHIFT_IMPL > 1 || LZC_IMPL < 0 || LZC_IMPL > 1) begin : g_bad_impl
      $error("int_exec_unit: SHIFT_IMPL and LZC_IMPL must be 0 or 1");
   end

   alu_ctl_t        ctl;
   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] opnd_b;
   logic [XLEN-1:0] sum;
   logic            raw_ovf;
   logic [XLEN-1:0] bit_res;
   logic [XLEN-1:0] sh_res;
   logic [SHW-1:0]  sh_amt;
   logic [XLEN-1:0] cnt_src;
   logic [CW-1:0]   cnt;
   logic            less;

   int_alu_decode u_decode (
      .op_i  (op_i),
      .ctl_o (ctl)
   );

   always_comb begin
      imm_ext = ctl.imm_sext ? {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i}
                             : {{(XLEN-IMMW){1'b0}}, imm_i};
      opnd_b  = ctl.use_imm ? imm_ext : rt_val_i;
   end

   int_alu_addsub #(.XLEN(XLEN)) u_addsub (
      .a_i   (rs_val_i),
      .b_i   (opnd_b),
      .sub_i (ctl.subtract),
      .sum_o (sum),
      .ovf_o (raw_ovf)
   );

   always_comb begin
      case (ctl.bit_fn)
         BIT_AND: bit_res = rs_val_i & opnd_b;
         BIT_OR:  bit_res = rs_val_i | opnd_b;
         BIT_XOR: bit_res = rs_val_i ^ opnd_b;
         default: bit_res = ~(rs_val_i | opnd_b);
      endcase
   end

   assign sh_amt = ctl.sh_var ? rs_val_i[SHW-1:0] : shamt_i;

   int_alu_shifter #(.XLEN(XLEN), .IMPL(SHIFT_IMPL)) u_shift (
      .val_i  (rt_val_i),
      .amt_i  (sh_amt),
      .kind_i (ctl.sh_kind),
      .out_o  (sh_res)
   );

   assign cnt_src = ctl.cnt_ones ? ~rs_val_i : rs_val_i;

   int_alu_lzc #(.XLEN(XLEN), .IMPL(LZC_IMPL)) u_lzc (
      .val_i (cnt_src),
      .cnt_o (cnt)
   );

   assign less = sum[XLEN-1] ^ raw_ovf;

   always_comb begin
      case (ctl.grp)
         GRP_ARITH: result_o = sum;
         GRP_BITOP: result_o = bit_res;
         GRP_SHIFT: result_o = sh_res;
         GRP_LESS:  result_o = {{(XLEN-1){1'b0}}, less};
         GRP_COUNT: result_o = {{(XLEN-CW){1'b0}}, cnt};
         default:   result_o = '0;
      endcase
      ovf_trap_o = ctl.may_trap & raw_ovf;
      wr_en_o    = ctl.valid & ~ovf_trap_o;
   end

   always_comb begin
      AST_TRAP_BLOCKS_WRITE: assert (!(ovf_trap_o && wr_en_o)); // R4
      if (op_i == OP_ADDU || op_i == OP_ADDIU || op_i == OP_SUBU) begin
         AST_NO_OVERFLOW: assert (!ovf_trap_o); // R3
      end
      if (op_i == OP_ADD && ovf_trap_o) begin
         AST_ADD_TRAP_SIGNS: assert (rs_val_i[XLEN-1] == rt_val_i[XLEN-1] &&
                                     result_o[XLEN-1] != rs_val_i[XLEN-1]); // R2
      end
      if (op_i == OP_SLT || op_i == OP_SLTI) begin
         AST_LESS_IS_BIT: assert (result_o[XLEN-1:1] == '0 && wr_en_o); // R10
      end
      if (op_i == OP_CLZ || op_i == OP_CLO) begin
         AST_COUNT_LIMIT: assert (result_o <= XLEN); // R11
      end
      if (op_i > OP_CLO) begin
         AST_UNDEF_IDLE: assert (!wr_en_o && !ovf_trap_o && result_o == '0); // R4
      end
   end

endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;

   localparam logic [4:0] ADD = 5'd0, ADDU = 5'd1, SUB = 5'd2, SUBU = 5'd3,
                          ADDI = 5'd4, ADDIU = 5'd5, AND_ = 5'd6, OR_ = 5'd7,
                          XOR_ = 5'd8, NOR_ = 5'd9, ANDI = 5'd10, ORI = 5'd11,
                          XORI = 5'd12, SLL = 5'd13, SRL = 5'd14, SRA = 5'd15,
                          SLLV = 5'd16, SRLV = 5'd17, SRAV = 5'd18, SLT = 5'd19,
                          SLTI = 5'd20, CLZ = 5'd21, CLO = 5'd22;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  op;
   logic [31:0] rs_val, rt_val;
   logic [15:0] imm;
   logic [4:0]  shamt;
   logic [31:0] result;
   logic        ovf_trap, wr_en;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   int_exec_unit u_dut (
      .op_i       (op),
      .rs_val_i   (rs_val),
      .rt_val_i   (rt_val),
      .imm_i      (imm),
      .shamt_i    (shamt),
      .result_o   (result),
      .ovf_trap_o (ovf_trap),
      .wr_en_o    (wr_en)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic apply(input string tag, input logic [4:0] o,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [4:0] sh,
                        input logic [31:0] exp_r, input logic exp_ov,
                        input logic exp_we);
      @(negedge clk);
      op = o; rs_val = a; rt_val = b; imm = im; shamt = sh;
      #2;
      chk(tag, "result", result, exp_r);
      chk(tag, "trap", {31'b0, ovf_trap}, {31'b0, exp_ov});
      chk(tag, "wr_en", {31'b0, wr_en}, {31'b0, exp_we});
   endtask

   task automatic t_reset;
      apply("R1 reset idle add", ADD, 0, 0, 0, 0, 32'h0, 1'b0, 1'b1);
   endtask

   task automatic t_arith;
      apply("R1 add", ADD, 5, 7, 0, 0, 32'd12, 0, 1);
      apply("R1 addu wrap", ADDU, 32'hFFFF_FFFF, 1, 0, 0, 32'h0, 0, 1);
      apply("R1 sub", SUB, 3, 5, 0, 0, 32'hFFFF_FFFE, 0, 1);
      apply("R1 subu", SUBU, 32'h1000, 1, 0, 0, 32'h0FFF, 0, 1);
      apply("R5 addi sext", ADDI, 10, 32'hDEAD, 16'hFFFF, 0, 32'd9, 0, 1);
      apply("R5 addiu sext", ADDIU, 0, 0, 16'h8000, 0, 32'hFFFF_8000, 0, 1);
   endtask

   task automatic t_overflow;
      apply("R2 add pos ovf", ADD, 32'h7FFF_FFFF, 1, 0, 0, 32'h8000_0000, 1, 0);
      apply("R2 add neg ovf", ADD, 32'h8000_0000, 32'h8000_0000, 0, 0, 32'h0, 1, 0);
      apply("R2 add mixed ok", ADD, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 32'hFFFF_FFFF, 0, 1);
      apply("R2 sub zero-min", SUB, 0, 32'h8000_0000, 0, 0, 32'h8000_0000, 1, 0);
      apply("R2 sub min-one", SUB, 32'h8000_0000, 1, 0, 0, 32'h7FFF_FFFF, 1, 0);
      apply("R2 sub neg-min ok", SUB, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, 32'h7FFF_FFFF, 0, 1);
      apply("R2 addi ovf", ADDI, 32'h7FFF_FFFF, 0, 16'h0001, 0, 32'h8000_0000, 1, 0);
      apply("R2 addi neg ovf", ADDI, 32'h8000_0000, 0, 16'hFFFF, 0, 32'h7FFF_FFFF, 1, 0);
      apply("R3 addu no trap", ADDU, 32'h7FFF_FFFF, 1, 0, 0, 32'h8000_0000, 0, 1);
      apply("R3 subu no trap", SUBU, 32'h8000_0000, 1, 0, 0, 32'h7FFF_FFFF, 0, 1);
      apply("R3 addiu no trap", ADDIU, 32'h8000_0000, 0, 16'hFFFF, 0, 32'h7FFF_FFFF, 0, 1);
   endtask

   task automatic t_logic;
      apply("R7 and", AND_, 32'hF0F0_1234, 32'hFF00_FF0F, 0, 0, 32'hF000_1204, 0, 1);
      apply("R7 or", OR_, 32'hF0F0_1234, 32'h0F00_0001, 0, 0, 32'hFFF0_1235, 0, 1);
      apply("R7 xor", XOR_, 32'hAAAA_5555, 32'hFFFF_0000, 0, 0, 32'h5555_5555, 0, 1);
      apply("R7 nor", NOR_, 32'hF0F0_0000, 32'h0F00_0001, 0, 0, 32'h000F_FFFE, 0, 1);
   endtask

   task automatic t_imm_ext;
      apply("R6 andi zext", ANDI, 32'hFFFF_FFFF, 0, 16'h8001, 0, 32'h0000_8001, 0, 1);
      apply("R6 ori zext", ORI, 0, 32'hFFFF_FFFF, 16'hFFFF, 0, 32'h0000_FFFF, 0, 1);
      apply("R6 xori zext", XORI, 32'hFFFF_0000, 0, 16'h8000, 0, 32'hFFFF_8000, 0, 1);
   endtask

   task automatic t_shift_const;
      apply("R8 sll", SLL, 0, 32'h1, 0, 5'd31, 32'h8000_0000, 0, 1);
      apply("R8 srl zero fill", SRL, 0, 32'h8000_0000, 0, 5'd31, 32'h1, 0, 1);
      apply("R8 sra sign fill", SRA, 0, 32'h8000_0000, 0, 5'd4, 32'hF800_0000, 0, 1);
      apply("R8 sra positive", SRA, 0, 32'h4000_0000, 0, 5'd30, 32'h1, 0, 1);
      apply("R8 sll zero amt", SLL, 0, 32'h1234_5678, 0, 5'd0, 32'h1234_5678, 0, 1);
   endtask

   task automatic t_shift_var;
      apply("R9 sllv low bits", SLLV, 32'hFFFF_FFE4, 32'h1, 0, 5'd3, 32'h10, 0, 1);
      apply("R9 srav amt 32 is 0", SRAV, 32'h20, 32'h8000_0000, 0, 5'd7, 32'h8000_0000, 0, 1);
      apply("R9 srlv", SRLV, 32'h1F, 32'hF000_0000, 0, 5'd0, 32'h1, 0, 1);
      apply("R9 srav sign", SRAV, 32'h8, 32'h8000_00F0, 0, 5'd1, 32'hFF80_0000, 0, 1);
   endtask

   task automatic t_less;
      apply("R10 slt neg<pos", SLT, 32'hFFFF_FFFF, 1, 0, 0, 32'h1, 0, 1);
      apply("R10 slt pos<neg", SLT, 1, 32'hFFFF_FFFF, 0, 0, 32'h0, 0, 1);
      apply("R10 slt min<max", SLT, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 32'h1, 0, 1);
      apply("R10 slt max<min", SLT, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 32'h0, 0, 1);
      apply("R10 slt equal", SLT, 32'h55, 32'h55, 0, 0, 32'h0, 0, 1);
      apply("R10 slti sext", SLTI, 32'hFFFF_FFFE, 0, 16'hFFFF, 0, 32'h1, 0, 1);
      apply("R10 slti vs neg imm", SLTI, 5, 0, 16'h8000, 0, 32'h0, 0, 1);
   endtask

   task automatic t_count;
      apply("R11 clz zero", CLZ, 0, 0, 0, 0, 32'd32, 0, 1);
      apply("R11 clz one", CLZ, 1, 0, 0, 0, 32'd31, 0, 1);
      apply("R11 clz msb", CLZ, 32'h8000_0000, 0, 0, 0, 32'd0, 0, 1);
      apply("R11 clz mid", CLZ, 32'h0001_0000, 0, 0, 0, 32'd15, 0, 1);
      apply("R11 clo all ones", CLO, 32'hFFFF_FFFF, 0, 0, 0, 32'd32, 0, 1);
      apply("R11 clo nibble", CLO, 32'hF000_0000, 0, 0, 0, 32'd4, 0, 1);
      apply("R11 clo none", CLO, 32'h7FFF_FFFF, 0, 0, 0, 32'd0, 0, 1);
      apply("R11 clo 31", CLO, 32'hFFFF_FFFE, 0, 0, 0, 32'd31, 0, 1);
   endtask

   task automatic t_undefined;
      apply("R4 undefined 23", 5'd23, 32'h7FFF_FFFF, 1, 16'h1, 5'd1, 32'h0, 0, 0);
      apply("R4 undefined 31", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, 32'h0, 0, 0);
   endtask

   initial begin
      op = ADD; rs_val = '0; rt_val = '0; imm = '0; shamt = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset();
      t_arith();
      t_overflow();
      t_logic();
      t_imm_ext();
      t_shift_const();
      t_shift_var();
      t_less();
      t_count();
      t_undefined();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule